// File: doc/BRIEF.md
# Steerable Vectored Interrupt Controller

The block gathers 32 level-sensitive request lines and drives two request outputs toward a processor core. One output is a fast request, and the other is a normal request. Software places each line in one of two classes. A fast-class line feeds the fast output directly. A normal-class line enters a priority resolver. Each normal-class line has its own 4-bit priority and its own 32-bit handler address.

The core's handler reads the vector register to fetch the address of the winning line. That read also claims the winner, which masks every line of equal or lower priority. Writing the vector register ends service and re-opens presentation to all lines. Software can change priorities while the block runs.

A software force mask is ORed into the physical lines. The register port is a simple one: address, write strobe, read strobe and data. Read data is combinational from the address.

Top module: `intr_vector_ctrl`

## Requirements
- R1: After reset, both request outputs are low. The enable, class and force masks read 0. Every priority reads 15. The default vector reads 0.
- R2: Word address 0 reads the raw request state, which is the physical lines ORed with the force mask (address 3). The raw state is shown whether or not a line is enabled.
- R3: A line whose bit in the enable mask (address 1) is 0 never drives either request output, and never wins the vector.
- R4: The fast output equals the OR of all enabled, pending lines whose class bit (address 2) is 1. It follows the inputs one clock later, whatever the service state.
- R5: A fast-class line never drives the normal output and never wins the vector. The normal output is high one clock after any enabled, pending, normal-class line becomes eligible.
- R6: Reading address 6 returns the handler address of the eligible normal-class line with the smallest priority value. Priority 0 is the most urgent. On a tie, the lower line index wins. Priorities sit at address 32+i and handler addresses at address 64+i.
- R7: A write to a priority register changes the winner on the next cycle, with no reset needed.
- R8: When no normal-class line is eligible, address 6 returns the default vector held at address 7.
- R9: A read strobe at address 6 with a winner present claims that winner's priority. Until address 6 is written, only lines with a strictly smaller priority value are eligible. The write ends the service and restores all lines.
- R10: A bit set in the force mask requests exactly like the matching physical line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 32 | Level-sensitive request lines |
| regAddr | input | 7 | Register word address |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (claims on address 6) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| fiqOut | output | 1 | Fast request output |
| irqOut | output | 1 | Normal request output |

## Verification
The line, enable and class patterns are chosen so that each one separates a single behaviour:
- a lone line against two lines with different priorities, which exposes priority order;
- two lines sharing priority 0, which exposes the tie-break by index;
- a lone disabled line, which shows that the enable mask gates both outputs;
- a mix of classes, which shows that a fast-class line never captures the vector while its output still rises;
- every line high at once, which stresses the full resolver.

Directed sequences cover further cases:
- a priority rewrite, which flips the winner at run time;
- a claim and release, which shows an equal-priority line held off and a more urgent line let through;
- the force mask standing in for a physical line.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;
  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned PRIO_W  = 4;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  // word addresses of the register file
  localparam logic [ADDR_W-1:0] A_RAW   = 7'h00;
  localparam logic [ADDR_W-1:0] A_EN    = 7'h01;
  localparam logic [ADDR_W-1:0] A_CLASS = 7'h02;
  localparam logic [ADDR_W-1:0] A_FORCE = 7'h03;
  localparam logic [ADDR_W-1:0] A_FIQST = 7'h04;
  localparam logic [ADDR_W-1:0] A_IRQST = 7'h05;
  localparam logic [ADDR_W-1:0] A_VEC   = 7'h06;
  localparam logic [ADDR_W-1:0] A_DEFV  = 7'h07;
  // banked regions, selected by the bits above the index
  localparam logic [ADDR_W-IDX_W-1:0] B_PRIO = 2'b01;
  localparam logic [ADDR_W-IDX_W-1:0] B_VECT = 2'b10;

  typedef struct packed {
    logic wrEn;
    logic wrClass;
    logic wrForce;
    logic wrDefVec;
    logic wrPrio;
    logic wrVect;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/intr_vec_ctl.sv
module intr_vec_ctl
  import intr_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              winValid,
  input  logic [PRIO_W-1:0] winPrio,
  output regStrobe_t        strobe,
  output logic              svcActive,
  output logic [PRIO_W-1:0] svcPrio
);
  logic [ADDR_W-IDX_W-1:0] bank;
  logic claim, done;

  assign bank  = regAddr[ADDR_W-1:IDX_W];
  assign claim = regRe && (regAddr == A_VEC) && winValid;
  assign done  = regWe && (regAddr == A_VEC);

  always_comb begin
    strobe     = '0;
    strobe.idx = regAddr[IDX_W-1:0];
    if (regWe) begin
      strobe.wrEn     = (regAddr == A_EN);
      strobe.wrClass  = (regAddr == A_CLASS);
      strobe.wrForce  = (regAddr == A_FORCE);
      strobe.wrDefVec = (regAddr == A_DEFV);
      strobe.wrPrio   = (bank == B_PRIO);
      strobe.wrVect   = (bank == B_VECT);
    end
  end

  // single-level service state: end of service wins over a new claim
  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcActive <= 1'b0;
      svcPrio   <= '1;
    end else if (done) begin
      svcActive <= 1'b0;
      svcPrio   <= '1;
    end else if (claim) begin
      svcActive <= 1'b1;
      svcPrio   <= winPrio;
    end
  end
endmodule

// File: rtl/intr_vec_dp.sv
module intr_vec_dp
  import intr_vec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               svcActive,
  input  logic [PRIO_W-1:0]  svcPrio,
  output logic [DATA_W-1:0]  regRdata,
  output logic               fiqOut,
  output logic               irqOut,
  output logic               winValid,
  output logic [PRIO_W-1:0]  winPrio,
  output logic [NUM_SRC-1:0] rawStat,
  output logic [NUM_SRC-1:0] enMask,
  output logic [NUM_SRC-1:0] classMask
);
  logic [NUM_SRC-1:0] forceMask, fiqPend, irqPend, eligible;
  logic [DATA_W-1:0]  defVec;
  logic [PRIO_W-1:0]  prioArr [NUM_SRC];
  logic [DATA_W-1:0]  vectArr [NUM_SRC];
  logic [IDX_W-1:0]   winIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask    <= '0;
      classMask <= '0;
      forceMask <= '0;
      defVec    <= '0;
    end else begin
      if (strobe.wrEn)     enMask    <= regWdata[NUM_SRC-1:0];
      if (strobe.wrClass)  classMask <= regWdata[NUM_SRC-1:0];
      if (strobe.wrForce)  forceMask <= regWdata[NUM_SRC-1:0];
      if (strobe.wrDefVec) defVec    <= regWdata;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioArr[g] <= '1;
        vectArr[g] <= '0;
      end else begin
        if (strobe.wrPrio && strobe.idx == IDX_W'(g)) prioArr[g] <= regWdata[PRIO_W-1:0];
        if (strobe.wrVect && strobe.idx == IDX_W'(g)) vectArr[g] <= regWdata;
      end
    end
    assign eligible[g] = irqPend[g] && (!svcActive || prioArr[g] < svcPrio);
  end

  assign rawStat = irqLines | forceMask;
  assign fiqPend = rawStat & enMask & classMask;
  assign irqPend = rawStat & enMask & ~classMask;

  // strict compare in index order: the lower index keeps a tie
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!winValid || prioArr[i] < winPrio)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioArr[i];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr[ADDR_W-1:IDX_W])
      B_PRIO:  regRdata = DATA_W'(prioArr[regAddr[IDX_W-1:0]]);
      B_VECT:  regRdata = vectArr[regAddr[IDX_W-1:0]];
      default: begin
        case (regAddr)
          A_RAW:   regRdata = DATA_W'(rawStat);
          A_EN:    regRdata = DATA_W'(enMask);
          A_CLASS: regRdata = DATA_W'(classMask);
          A_FORCE: regRdata = DATA_W'(forceMask);
          A_FIQST: regRdata = DATA_W'(fiqPend);
          A_IRQST: regRdata = DATA_W'(irqPend);
          A_VEC:   regRdata = winValid ? vectArr[winIdx] : defVec;
          A_DEFV:  regRdata = defVec;
          default: regRdata = '0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fiqOut <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      fiqOut <= |fiqPend;
      irqOut <= winValid;
    end
  end
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import intr_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       irqLines,
  input  logic [6:0]        regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              fiqOut,
  output logic              irqOut
);
  regStrobe_t         strobe;
  logic               svcActive, winValid;
  logic [PRIO_W-1:0]  svcPrio, winPrio;
  logic [NUM_SRC-1:0] rawStat, enMask, classMask;

  intr_vec_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .winValid(winValid), .winPrio(winPrio), .strobe(strobe),
    .svcActive(svcActive), .svcPrio(svcPrio)
  );

  intr_vec_dp u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .strobe(strobe),
    .regWdata(regWdata), .regAddr(regAddr), .svcActive(svcActive),
    .svcPrio(svcPrio), .regRdata(regRdata), .fiqOut(fiqOut), .irqOut(irqOut),
    .winValid(winValid), .winPrio(winPrio), .rawStat(rawStat),
    .enMask(enMask), .classMask(classMask)
  );
endmodule

// File: rtl/intr_vector_ctrl_chk.sv
module intr_vector_ctrl_chk
  import intr_vec_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWe,
  input logic               regRe,
  input logic               fiqOut,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] rawStat,
  input logic [NUM_SRC-1:0] enMask,
  input logic [NUM_SRC-1:0] classMask,
  input logic               svcActive
);
  // R3: nothing enabled and pending leaves both outputs low
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStat & enMask) == '0) |=> (!fiqOut && !irqOut));

  // R4: fast output tracks enabled fast-class requests one clock later
  p_fiq_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|(rawStat & enMask & classMask)) |=> fiqOut);

  // R5: no enabled normal-class request leaves the normal output low
  p_irq_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStat & enMask & ~classMask) == '0) |=> !irqOut);

  // R9: service starts only after a read strobe on the vector register
  p_claim_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcActive) |-> $past(regRe && regAddr == A_VEC));

  // R9: service ends only after a write to the vector register
  p_release_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(svcActive) |-> $past(regWe && regAddr == A_VEC));
endmodule

bind intr_vector_ctrl intr_vector_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
  .fiqOut(fiqOut), .irqOut(irqOut), .rawStat(rawStat), .enMask(enMask),
  .classMask(classMask), .svcActive(svcActive)
);

// File: tb/intr_vector_ctrl_tb.sv
module intr_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [31:0] DEFV = 32'hDEAD0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] irqLines = '0, regWdata = '0, regRdata;
  logic [6:0]  regAddr = '0;
  logic regWe = 1'b0, regRe = 1'b0, fiqOut, irqOut;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_vector_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regAddr(regAddr),
    .regWe(regWe), .regRe(regRe), .regWdata(regWdata), .regRdata(regRdata),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );

  // prio[i] = 15 - (i % 16), vector[i] = 0x100 + i
  localparam logic [31:0] T_LINES [NV] = '{32'h0, 32'h1, 32'h3, 32'h80008000, 32'h8000,
    32'h8001, 32'h8000, 32'h8000, 32'h00F0, 32'hFFFFFFFF};
  localparam logic [31:0] T_EN    [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'hFFFFFFFF, 32'h00007FFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [31:0] T_CLS   [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h8000, 32'h8000, 32'h8000, 32'h0, 32'hFFFF0000};
  localparam logic T_FIQ [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 1};
  localparam logic T_IRQ [NV] = '{0, 1, 1, 1, 0, 1, 0, 0, 1, 1};
  localparam logic [31:0] T_VEC [NV] = '{DEFV, 32'h100, 32'h101, 32'h10F, DEFV,
    32'h100, DEFV, DEFV, 32'h107, 32'h10F};
  localparam string T_REQ [NV] = '{"R8", "R5", "R6", "R6", "R3", "R5", "R4", "R3", "R6", "R6"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic peek(input logic [6:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {30'h0, fiqOut, irqOut}, 32'h0);
    peek(7'h01, v); chk("R1", v, 32'h0);
    peek(7'h25, v); chk("R1", v, 32'hF);
    peek(7'h06, v); chk("R1", v, 32'h0);

    wr(7'h07, DEFV);
    for (int i = 0; i < 32; i++) begin
      wr(7'(7'h20 + i), 32'(15 - (i % 16)));
      wr(7'(7'h40 + i), 32'(32'h100 + i));
    end

    for (int k = 0; k < NV; k++) begin
      wr(7'h01, T_EN[k]);
      wr(7'h02, T_CLS[k]);
      irqLines = T_LINES[k];
      settle();
      chk(T_REQ[k], {31'h0, fiqOut}, {31'h0, T_FIQ[k]});
      chk(T_REQ[k], {31'h0, irqOut}, {31'h0, T_IRQ[k]});
      peek(7'h06, v); chk(T_REQ[k], v, T_VEC[k]);
      peek(7'h00, v); chk("R2", v, T_LINES[k]);
    end

    // R7: run-time priority change
    wr(7'h01, 32'hFFFFFFFF);
    wr(7'h02, 32'h0);
    irqLines = 32'h3;
    settle();
    peek(7'h06, v); chk("R7", v, 32'h101);
    wr(7'h20, 32'h0);
    settle();
    peek(7'h06, v); chk("R7", v, 32'h100);

    // R9: claim masks equal priority, lets a more urgent line through
    irqLines = 32'h2;
    settle();
    chk("R9", {31'h0, irqOut}, 32'h1);
    regAddr = 7'h06; regRe = 1'b1;
    @(negedge clk);
    regRe = 1'b0;
    settle();
    chk("R9", {31'h0, irqOut}, 32'h0);
    peek(7'h06, v); chk("R9", v, DEFV);
    irqLines = 32'h3;
    settle();
    chk("R9", {31'h0, irqOut}, 32'h1);
    peek(7'h06, v); chk("R9", v, 32'h100);
    irqLines = 32'h2;
    wr(7'h06, 32'h0);
    settle();
    chk("R9", {31'h0, irqOut}, 32'h1);
    peek(7'h06, v); chk("R9", v, 32'h101);

    // R10: force mask acts like a line
    irqLines = 32'h0;
    wr(7'h03, 32'h4);
    settle();
    chk("R10", {31'h0, irqOut}, 32'h1);
    peek(7'h06, v); chk("R10", v, 32'h102);
    peek(7'h00, v); chk("R10", v, 32'h4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule